// File: doc/BRIEF.md
# Privilege Level and Interrupt Routing Controller

This block keeps the privilege level of one processor core and decides, every clock cycle, whether an asynchronous event is taken and at which level it is handled. The core runs at level 0 (applications, unprivileged), level 1 (guest operating system) or level 2 (hypervisor). Three event classes arrive as request vectors: a normal interrupt, a fast interrupt and an asynchronous abort. Each class can be raised as a physical request, or as a virtual request that hypervisor software has injected.

For each class, the router combines a mask bit, a hypervisor trap-enable bit and the current level into a candidate destination. The trap pushes physical events raised below level 2 straight to the hypervisor, whatever the masks say. A fixed priority then picks a single winner. Taking an event moves the core to the handler level at the next edge. It also produces a one-cycle taken pulse that carries the class code, the handler level and a virtual flag.

Exception returns arrive as a request with a target level. A return may only keep the level or lower it. A return that asks to go higher is refused: the level is held and a one-cycle illegal flag is raised.

Top module: `priv_route_ctrl`

## Requirements
- R1: After reset the level is 2, and the taken pulse, the virtual flag and the illegal-return flag are all low.
- R2: A physical event of a class whose trap bit is set, raised while the level is 0 or 1, is taken to handler level 2 even when that class's mask bit is set.
- R3: With the trap bit set and the level at 2, a physical event is taken at level 2 only when its mask bit is clear, and is not taken when the mask bit is set.
- R4: With the trap bit clear, an unmasked physical event is taken at level 1 from level 0 or 1, and at level 2 from level 2. A masked one is not taken.
- R5: An unmasked virtual event is taken at level 1, with the virtual flag high, from level 0 or 1. A virtual event that is masked, or that is raised while the level is 2, is not taken, and the level stays the same.
- R6: Bit positions in phys_req, virt_req, mask_bits and trap_cfg are: bit 0 normal interrupt, bit 1 fast interrupt, bit 2 asynchronous abort. The class code is 0 for normal, 1 for fast and 2 for abort. Among classes that can be taken, the higher code wins. Within one class, a physical request beats a virtual one.
- R7: When an event is accepted in a cycle, then after the next rising edge: level_o equals the handler level, taken_o is high, and taken_class_o and taken_virt_o describe the winner. taken_o is low after any cycle in which no event was accepted.
- R8: A return whose target is at or below the current level sets the level to the target at the next edge, and does not raise the illegal flag.
- R9: A return whose target is above the current level, including target 3, leaves the level unchanged and raises eret_illegal_o for exactly one cycle.
- R10: If an event is accepted in the same cycle as a return request, the event is taken and the return is discarded, with no illegal flag.
- R11: The level is never 3. A taken event never has handler level 0 and never lowers the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phys_req | input | 3 | Physical event requests, one bit per class |
| virt_req | input | 3 | Virtual (hypervisor-injected) event requests, one bit per class |
| mask_bits | input | 3 | Per-class mask bits |
| trap_cfg | input | 3 | Per-class hypervisor trap enables |
| eret_valid | input | 1 | Exception return request |
| eret_level | input | 2 | Target level of the return |
| level_o | output | 2 | Current privilege level |
| taken_o | output | 1 | One-cycle pulse: an event was taken |
| taken_class_o | output | 2 | Class code of the taken event |
| handler_level_o | output | 2 | Level at which the taken event is handled |
| taken_virt_o | output | 1 | Taken event was a virtual one |
| eret_illegal_o | output | 1 | One-cycle pulse: a return was refused |

## Verification
Routing is tried from each starting level with each class as a lone request, once with the mask set and once with it clear, and once with the trap set and once with it clear. This separates trap override from mask gating, and hypervisor-level handling from guest-level handling. Mixed patterns then pair two classes, or a physical and a virtual request. These show whether the class priority and the physical-before-virtual rule are applied, including a case where a masked higher class must give way to a trapped lower one. Returns are driven to every target from every level, so each legal drop and each refused raise appears. A collision between an event and a return checks which of the two wins.

// File: rtl/priv_route_pkg.sv
package priv_route_pkg;

  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_APP = 2'd0;
  localparam lvl_t LVL_OS  = 2'd1;
  localparam lvl_t LVL_HYP = 2'd2;

  // Candidate destination of one event class
  typedef struct packed {
    logic take;
    logic virt;
    lvl_t dest;
  } route_t;

  // Routing decision for one class: trap override first, then unmasked
  // physical delivery, then virtual delivery to the guest level.
  function automatic route_t route_class(input logic phys, input logic virt,
                                         input logic trap, input logic msk,
                                         input lvl_t cur);
    route_t r;
    r = '0;
    if (phys && trap && cur != LVL_HYP) begin
      r.take = 1'b1;
      r.dest = LVL_HYP;
    end else if (phys && !msk) begin
      r.take = 1'b1;
      r.dest = (cur == LVL_HYP) ? LVL_HYP : LVL_OS;
    end else if (virt && !msk && cur != LVL_HYP) begin
      r.take = 1'b1;
      r.virt = 1'b1;
      r.dest = LVL_OS;
    end
    return r;
  endfunction

  // A return may keep or lower the level, and never go above the top level
  function automatic logic eret_legal(input lvl_t cur, input lvl_t tgt);
    return (tgt <= cur) && (tgt <= LVL_HYP);
  endfunction

endpackage

// File: rtl/priv_route_class_path.sv
module priv_route_class_path
  import priv_route_pkg::*;
(
  input  logic   phys,
  input  logic   virt,
  input  logic   trap,
  input  logic   msk,
  input  lvl_t   cur,
  output route_t route
);

  always_comb route = route_class(phys, virt, trap, msk, cur);

endmodule

// File: rtl/priv_route_arb.sv
module priv_route_arb
  import priv_route_pkg::*;
#(
  parameter int NUM_CLS = 3,
  localparam int CLS_W = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
  input  route_t             routes [NUM_CLS],
  output route_t             win,
  output logic [CLS_W-1:0]   win_cls
);

  // Highest class index that can be taken wins
  always_comb begin
    win     = '0;
    win_cls = '0;
    for (int i = 0; i < NUM_CLS; i++) begin
      if (routes[i].take) begin
        win     = routes[i];
        win_cls = CLS_W'(i);
      end
    end
  end

endmodule

// File: rtl/priv_route_state.sv
module priv_route_state
  import priv_route_pkg::*;
#(
  parameter int CLS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_accept,
  input  route_t           evt_route,
  input  logic [CLS_W-1:0] evt_cls,
  input  logic             ret_accept,
  input  logic             ret_reject,
  input  lvl_t             ret_level,
  output lvl_t             level_q,
  output logic             taken_q,
  output logic [CLS_W-1:0] cls_q,
  output lvl_t             hlevel_q,
  output logic             virt_q,
  output logic             illegal_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q   <= LVL_HYP;
      taken_q   <= 1'b0;
      cls_q     <= '0;
      hlevel_q  <= LVL_HYP;
      virt_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      taken_q   <= evt_accept;
      illegal_q <= ret_reject;
      if (evt_accept) begin
        level_q  <= evt_route.dest;
        cls_q    <= evt_cls;
        hlevel_q <= evt_route.dest;
        virt_q   <= evt_route.virt;
      end else begin
        virt_q <= 1'b0;
        if (ret_accept) level_q <= ret_level;
      end
    end
  end

endmodule

// File: rtl/priv_route_ctrl.sv
module priv_route_ctrl
  import priv_route_pkg::*;
#(
  parameter int NUM_CLS = 3,
  localparam int CLS_W = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLS-1:0] phys_req,
  input  logic [NUM_CLS-1:0] virt_req,
  input  logic [NUM_CLS-1:0] mask_bits,
  input  logic [NUM_CLS-1:0] trap_cfg,
  input  logic               eret_valid,
  input  logic [LVL_W-1:0]   eret_level,
  output logic [LVL_W-1:0]   level_o,
  output logic               taken_o,
  output logic [CLS_W-1:0]   taken_class_o,
  output logic [LVL_W-1:0]   handler_level_o,
  output logic               taken_virt_o,
  output logic               eret_illegal_o
);

  route_t             cls_route [NUM_CLS];
  route_t             win_route;
  logic [CLS_W-1:0]   win_cls;
  logic               accept_evt;
  logic               ret_ok;
  logic               ret_accept;
  logic               ret_reject;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    priv_route_class_path u_path (
      .phys  (phys_req[g]),
      .virt  (virt_req[g]),
      .trap  (trap_cfg[g]),
      .msk   (mask_bits[g]),
      .cur   (level_o),
      .route (cls_route[g])
    );
  end

  priv_route_arb #(.NUM_CLS(NUM_CLS)) u_arb (
    .routes  (cls_route),
    .win     (win_route),
    .win_cls (win_cls)
  );

  assign accept_evt = win_route.take;
  assign ret_ok     = eret_legal(level_o, eret_level);
  assign ret_accept = eret_valid && !accept_evt && ret_ok;
  assign ret_reject = eret_valid && !accept_evt && !ret_ok;

  priv_route_state #(.CLS_W(CLS_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_accept (accept_evt),
    .evt_route  (win_route),
    .evt_cls    (win_cls),
    .ret_accept (ret_accept),
    .ret_reject (ret_reject),
    .ret_level  (eret_level),
    .level_q    (level_o),
    .taken_q    (taken_o),
    .cls_q      (taken_class_o),
    .hlevel_q   (handler_level_o),
    .virt_q     (taken_virt_o),
    .illegal_q  (eret_illegal_o)
  );

endmodule

// File: rtl/priv_route_ctrl_chk.sv
module priv_route_ctrl_chk #(
  parameter int NUM_CLS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_CLS-1:0] phys_req,
  input logic [NUM_CLS-1:0] virt_req,
  input logic [NUM_CLS-1:0] trap_cfg,
  input logic               eret_valid,
  input logic               accept_evt,
  input logic [1:0]         level_o,
  input logic               taken_o,
  input logic [1:0]         handler_level_o,
  input logic               eret_illegal_o
);

  assert_level_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    level_o != 2'd3);

  assert_handler_not_app_R11: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> handler_level_o != 2'd0);

  assert_entry_not_lower_R11: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> handler_level_o >= $past(level_o));

  assert_level_matches_handler_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> level_o == handler_level_o);

  assert_illegal_keeps_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eret_illegal_o |-> level_o == $past(level_o));

  assert_return_only_lowers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!taken_o && level_o != $past(level_o)) |-> level_o < $past(level_o));

  assert_trap_forces_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (((phys_req & trap_cfg) != '0) && level_o != 2'd2) |=> taken_o);

  assert_virt_held_at_hyp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 2'd2 && phys_req == '0 && virt_req != '0) |=> !taken_o);

  assert_event_beats_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_valid && accept_evt) |=> !eret_illegal_o);

endmodule

bind priv_route_ctrl priv_route_ctrl_chk #(.NUM_CLS(NUM_CLS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .phys_req        (phys_req),
  .virt_req        (virt_req),
  .trap_cfg        (trap_cfg),
  .eret_valid      (eret_valid),
  .accept_evt      (accept_evt),
  .level_o         (level_o),
  .taken_o         (taken_o),
  .handler_level_o (handler_level_o),
  .eret_illegal_o  (eret_illegal_o)
);

// File: tb/priv_route_ctrl_test.sv
module priv_route_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] phys_req = '0, virt_req = '0, mask_bits = '0, trap_cfg = '0;
  logic       eret_valid = 1'b0;
  logic [1:0] eret_level = '0;
  logic [1:0] level_o, taken_class_o, handler_level_o;
  logic       taken_o, taken_virt_o, eret_illegal_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_route_ctrl uut (
    .clk(clk), .rst_n(rst_n), .phys_req(phys_req), .virt_req(virt_req),
    .mask_bits(mask_bits), .trap_cfg(trap_cfg), .eret_valid(eret_valid),
    .eret_level(eret_level), .level_o(level_o), .taken_o(taken_o),
    .taken_class_o(taken_class_o), .handler_level_o(handler_level_o),
    .taken_virt_o(taken_virt_o), .eret_illegal_o(eret_illegal_o)
  );

  // start level, requests, mask, trap, then expected take/class/handler/virt
  typedef struct packed {
    logic [1:0] start;
    logic [2:0] phys;
    logic [2:0] virt;
    logic [2:0] msk;
    logic [2:0] trap;
    logic       e_take;
    logic [1:0] e_cls;
    logic [1:0] e_hl;
    logic       e_virt;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 3'b001, 3'b000, 3'b001, 3'b001, 1'b1, 2'd0, 2'd2, 1'b0}, // R2
    '{2'd1, 3'b010, 3'b000, 3'b010, 3'b010, 1'b1, 2'd1, 2'd2, 1'b0}, // R2
    '{2'd2, 3'b001, 3'b000, 3'b001, 3'b001, 1'b0, 2'd0, 2'd0, 1'b0}, // R3
    '{2'd2, 3'b001, 3'b000, 3'b000, 3'b001, 1'b1, 2'd0, 2'd2, 1'b0}, // R3
    '{2'd0, 3'b100, 3'b000, 3'b000, 3'b000, 1'b1, 2'd2, 2'd1, 1'b0}, // R4
    '{2'd1, 3'b010, 3'b000, 3'b010, 3'b000, 1'b0, 2'd0, 2'd0, 1'b0}, // R4
    '{2'd2, 3'b010, 3'b000, 3'b000, 3'b000, 1'b1, 2'd1, 2'd2, 1'b0}, // R4
    '{2'd0, 3'b000, 3'b001, 3'b000, 3'b000, 1'b1, 2'd0, 2'd1, 1'b1}, // R5
    '{2'd1, 3'b000, 3'b010, 3'b010, 3'b000, 1'b0, 2'd0, 2'd0, 1'b0}, // R5
    '{2'd2, 3'b000, 3'b100, 3'b000, 3'b000, 1'b0, 2'd0, 2'd0, 1'b0}, // R5
    '{2'd1, 3'b011, 3'b000, 3'b000, 3'b000, 1'b1, 2'd1, 2'd1, 1'b0}, // R6
    '{2'd0, 3'b001, 3'b100, 3'b000, 3'b000, 1'b1, 2'd2, 2'd1, 1'b1}, // R6
    '{2'd1, 3'b001, 3'b001, 3'b000, 3'b000, 1'b1, 2'd0, 2'd1, 1'b0}, // R6
    '{2'd1, 3'b101, 3'b000, 3'b100, 3'b001, 1'b1, 2'd0, 2'd2, 1'b0}, // R6
    '{2'd1, 3'b101, 3'b000, 3'b000, 3'b001, 1'b1, 2'd2, 2'd1, 1'b0}  // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    phys_req = '0; virt_req = '0; mask_bits = '0; trap_cfg = '0;
    eret_valid = 1'b0; eret_level = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clear_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One-cycle return request; outputs sampled at the following negedge
  task automatic do_eret(input logic [1:0] tgt);
    eret_valid = 1'b1;
    eret_level = tgt;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic goto_level(input logic [1:0] lvl);
    do_reset();
    if (lvl != 2'd2) do_eret(lvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(level_o == 2'd2, "R1 level", level_o, 2);
    check(!taken_o && !taken_virt_o && !eret_illegal_o, "R1 flags",
          {taken_o, taken_virt_o, eret_illegal_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [1:0] exp_lvl;
      v = VECS[i];
      goto_level(v.start);
      phys_req = v.phys; virt_req = v.virt; mask_bits = v.msk; trap_cfg = v.trap;
      @(negedge clk);
      clear_inputs();
      exp_lvl = v.e_take ? v.e_hl : v.start;
      check(taken_o == v.e_take, "R7 taken per vector", taken_o, v.e_take);
      check(level_o == exp_lvl, "R7 level per vector", level_o, exp_lvl);
      if (v.e_take) begin
        check({taken_class_o, handler_level_o, taken_virt_o} ==
              {v.e_cls, v.e_hl, v.e_virt}, "R6 route per vector",
              {taken_class_o, handler_level_o, taken_virt_o},
              {v.e_cls, v.e_hl, v.e_virt});
        check(handler_level_o != 2'd0 && handler_level_o >= v.start,
              "R11 handler bound", handler_level_o, v.e_hl);
      end
      @(negedge clk);
      check(!taken_o, "R7 pulse ends", taken_o, 0);
      check(level_o == exp_lvl, "R7 level holds", level_o, exp_lvl);
    end

    // R8 legal returns
    goto_level(2'd2);
    do_eret(2'd2);
    check(level_o == 2'd2 && !eret_illegal_o, "R8 2->2", level_o, 2);
    do_eret(2'd1);
    check(level_o == 2'd1 && !eret_illegal_o, "R8 2->1", level_o, 1);
    do_eret(2'd0);
    check(level_o == 2'd0 && !eret_illegal_o, "R8 1->0", level_o, 0);
    do_eret(2'd0);
    check(level_o == 2'd0 && !eret_illegal_o, "R8 0->0", level_o, 0);

    // R9 illegal returns
    do_eret(2'd1);
    check(level_o == 2'd0 && eret_illegal_o, "R9 0->1",
          {level_o, eret_illegal_o}, {2'd0, 1'b1});
    @(negedge clk);
    check(!eret_illegal_o, "R9 flag one cycle", eret_illegal_o, 0);
    goto_level(2'd1);
    do_eret(2'd2);
    check(level_o == 2'd1 && eret_illegal_o, "R9 1->2",
          {level_o, eret_illegal_o}, {2'd1, 1'b1});
    goto_level(2'd2);
    do_eret(2'd3);
    check(level_o == 2'd2 && eret_illegal_o, "R9 2->3",
          {level_o, eret_illegal_o}, {2'd2, 1'b1});

    // R10 event and return in the same cycle
    goto_level(2'd1);
    phys_req = 3'b100; trap_cfg = 3'b100;
    eret_valid = 1'b1; eret_level = 2'd0;
    @(negedge clk);
    clear_inputs();
    check(taken_o && level_o == 2'd2 && !eret_illegal_o, "R10 event wins",
          {taken_o, level_o, eret_illegal_o}, {1'b1, 2'd2, 1'b0});
    goto_level(2'd0);
    phys_req = 3'b001;
    eret_valid = 1'b1; eret_level = 2'd2;
    @(negedge clk);
    clear_inputs();
    check(taken_o && level_o == 2'd1 && !eret_illegal_o, "R10 illegal discarded",
          {taken_o, level_o, eret_illegal_o}, {1'b1, 2'd1, 1'b0});

    // R2 with every class trapped and masked at level 0: abort wins, to level 2
    goto_level(2'd0);
    phys_req = 3'b111; mask_bits = 3'b111; trap_cfg = 3'b111;
    @(negedge clk);
    clear_inputs();
    check(taken_o && taken_class_o == 2'd2 && level_o == 2'd2, "R2 all trapped",
          {taken_class_o, level_o}, {2'd2, 2'd2});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule